// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Controller

This block sits next to a group of peripheral blocks and owns two things for each of them: whether its clock runs and whether it is held in reset. Software turns a clock on by writing that block's code word into a set-command register. It turns the clock off by writing the same code word into a clear-command register. Because each command names only one block, two software agents never have to read and rewrite a shared enable word.

Reset is kept as one bit per block in a 16-bit register. That register can be loaded whole, or bits can be asserted or released atomically through two mask registers. After power-up every block that supports reset is held in reset.

Not all blocks behave alike:
- Some clocks are owned by hardware and follow a request input instead of software.
- Some clocks cannot be gated at all.
- Some blocks have no reset.
- Some blocks have no status bit.
- One block is the console port. Once its clock is on it can never be turned off, and once its reset is released it can never be forced back into reset.

A 16-bit status register reports the state of every clock.

Top module: `periph_clkrst`

## Requirements
- R1: A write to address 0 (set command) with data `CODE_BASE + i` turns `clkEn[i]` on at the next clock edge, for a software-gated block i. A write of that same value to address 1 (clear command) turns it off at the next edge.
- R2: Command writes have no effect on any output in these cases: data 0xFFFF, data that matches no software-gated block (including codes of blocks at or above `NUM_BLOCKS`), or the code of an ungateable block.
- R3: For a block in `HW_OWNED_MASK`, `clkEn[i]` equals `hwClkReq[i]` in the same cycle, and set and clear commands for it have no effect.
- R4: For a block in `UNGATED_MASK`, `clkEn[i]` is always 1, including during reset.
- R5: After reset:
  - `blkRst` equals `HAS_RESET_MASK`, so every block that supports reset is held in reset.
  - All software-gated clocks are off.
  - The status register reads 1 for blocks without a status bit, and for ungated blocks.
- R6: A write to address 2 loads the reset register, where bit i = 1 holds block i in reset. Reading address 2 returns the register. Bits of blocks outside `HAS_RESET_MASK` read 0, and their `blkRst` output stays 0.
- R7: A write to address 3 sets the reset bits given by ones in the data. A write to address 4 clears the reset bits given by ones in the data. All other reset bits keep their value.
- R8: The console block `CONSOLE_IDX` is protected:
  - A clear command never turns its clock off.
  - Once its reset bit is 0, no write through address 2, 3 or 4 sets it to 1 again.
- R9: Reading address 5 returns the status word:
  - bit i is `clkEn[i]` for blocks in `HAS_STATUS_MASK`;
  - bit i is 1 for other blocks below `NUM_BLOCKS`;
  - bits at or above `NUM_BLOCKS` read 0.
- R10: Reads of addresses 0, 1, 6 and 7 return 0. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus and controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | 3 | Register address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data for `busAddr` |
| hwClkReq | input | NUM_BLOCKS | Clock requests for hardware-owned blocks |
| clkEn | output | NUM_BLOCKS | Per-block clock enable |
| blkRst | output | NUM_BLOCKS | Per-block reset, 1 = held in reset |

## Verification
Two functions can meet in one cycle: a software command and a change on a hardware clock request.

The bench holds a set or clear command on the bus for a hardware-owned block while it moves that block's `hwClkReq`. It then checks that `clkEn` follows only the request, and that software-gated neighbours keep their state.

A second overlap joins the console protection with a whole-register reset load. A load of all ones after the console's release must re-assert every supported block except the console. The expected word is worked out from the masks and compared with the reset register read back on the bus.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned ADDR_W  = 3;
  localparam logic [REG_W-1:0] NO_GATE_CODE = 16'hFFFF;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_EN_SET  = 3'd0,
    ADDR_EN_CLR  = 3'd1,
    ADDR_RST     = 3'd2,
    ADDR_RST_ON  = 3'd3,
    ADDR_RST_OFF = 3'd4,
    ADDR_STATUS  = 3'd5
  } regAddr_e;

  // Strobes from the command decoder to the state registers.
  typedef struct packed {
    logic [REG_W-1:0] enSet;
    logic [REG_W-1:0] enClr;
    logic             rstLoad;
    logic             rstOn;
    logic             rstOff;
    logic [REG_W-1:0] data;
  } ctrlStrobe_t;

endpackage

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int unsigned      NUM_BLOCKS    = 12,
  parameter logic [REG_W-1:0] CODE_BASE     = 16'h5A00,
  parameter logic [REG_W-1:0] HW_OWNED_MASK = 16'h0009,
  parameter logic [REG_W-1:0] UNGATED_MASK  = 16'h00C0,
  parameter int unsigned      CONSOLE_IDX   = 4
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output ctrlStrobe_t       strobe
);

  logic setWr;
  logic clrWr;
  logic codeLegal;
  logic [REG_W-1:0] codeHit;
  logic [REG_W-1:0] setVec;
  logic [REG_W-1:0] clrVec;

  assign setWr     = busWrEn && (busAddr == ADDR_EN_SET);
  assign clrWr     = busWrEn && (busAddr == ADDR_EN_CLR);
  assign codeLegal = (busWrData != NO_GATE_CODE);

  for (genvar i = 0; i < REG_W; i++) begin : g_dec
    if (i < NUM_BLOCKS) begin : g_live
      localparam logic [REG_W-1:0] MY_CODE  = REG_W'(CODE_BASE + i);
      localparam bit               GATEABLE = !HW_OWNED_MASK[i] && !UNGATED_MASK[i];
      localparam bit               GUARDED  = (i == CONSOLE_IDX);

      assign codeHit[i] = codeLegal && (busWrData == MY_CODE);

      if (GATEABLE) begin : g_sw
        assign setVec[i] = setWr && codeHit[i];
        if (GUARDED) begin : g_guard
          assign clrVec[i] = 1'b0;
        end else begin : g_free
          assign clrVec[i] = clrWr && codeHit[i];
        end
      end else begin : g_nosw
        assign setVec[i] = 1'b0;
        assign clrVec[i] = 1'b0;
      end
    end else begin : g_absent
      assign codeHit[i] = 1'b0;
      assign setVec[i]  = 1'b0;
      assign clrVec[i]  = 1'b0;
    end
  end

  always_comb begin
    strobe.enSet   = setVec;
    strobe.enClr   = clrVec;
    strobe.rstLoad = busWrEn && (busAddr == ADDR_RST);
    strobe.rstOn   = busWrEn && (busAddr == ADDR_RST_ON);
    strobe.rstOff  = busWrEn && (busAddr == ADDR_RST_OFF);
    strobe.data    = busWrData;
  end

endmodule

// File: rtl/pcg_dp.sv
module pcg_dp
  import pcg_pkg::*;
#(
  parameter int unsigned      NUM_BLOCKS     = 12,
  parameter logic [REG_W-1:0] HW_OWNED_MASK  = 16'h0009,
  parameter logic [REG_W-1:0] UNGATED_MASK   = 16'h00C0,
  parameter logic [REG_W-1:0] HAS_RESET_MASK = 16'h0F7F,
  parameter logic [REG_W-1:0] HAS_STATUS_MASK = 16'h0B3F,
  parameter int unsigned      CONSOLE_IDX    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [NUM_BLOCKS-1:0] hwClkReq,
  output logic [REG_W-1:0]      busRdData,
  output logic [NUM_BLOCKS-1:0] clkEn,
  output logic [NUM_BLOCKS-1:0] blkRst
);

  logic [REG_W-1:0] hwReq;
  logic [REG_W-1:0] validMask;
  logic [REG_W-1:0] rstMask;
  logic [REG_W-1:0] enReg;
  logic [REG_W-1:0] enNext;
  logic [REG_W-1:0] rstReg;
  logic [REG_W-1:0] rstCand;
  logic [REG_W-1:0] rstNext;
  logic [REG_W-1:0] clkVec;
  logic [REG_W-1:0] statusVec;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i < NUM_BLOCKS) begin : g_live
      assign hwReq[i]     = hwClkReq[i];
      assign validMask[i] = 1'b1;
      if (UNGATED_MASK[i]) begin : g_ungated
        assign clkVec[i] = 1'b1;
      end else if (HW_OWNED_MASK[i]) begin : g_hw
        assign clkVec[i] = hwReq[i];
      end else begin : g_sw
        assign clkVec[i] = enReg[i];
      end
      if (HAS_STATUS_MASK[i]) begin : g_stat
        assign statusVec[i] = clkVec[i];
      end else begin : g_nostat
        assign statusVec[i] = 1'b1;
      end
    end else begin : g_absent
      assign hwReq[i]     = 1'b0;
      assign validMask[i] = 1'b0;
      assign clkVec[i]    = 1'b0;
      assign statusVec[i] = 1'b0;
    end
  end

  assign rstMask = HAS_RESET_MASK & validMask;

  // Software enable state: read-modify-write in one edge.
  always_comb begin
    enNext = (enReg | strobe.enSet) & ~strobe.enClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0;
    end else begin
      enReg <= enNext;
    end
  end

  // Reset state with the console release made one-way.
  always_comb begin
    rstCand = rstReg;
    if (strobe.rstLoad) begin
      rstCand = strobe.data;
    end else if (strobe.rstOn) begin
      rstCand = rstReg | strobe.data;
    end else if (strobe.rstOff) begin
      rstCand = rstReg & ~strobe.data;
    end
    rstNext = rstCand & rstMask;
    rstNext[CONSOLE_IDX] = rstCand[CONSOLE_IDX] & rstReg[CONSOLE_IDX];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReg <= rstMask;
    end else begin
      rstReg <= rstNext;
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_RST:    busRdData = rstReg;
      ADDR_STATUS: busRdData = statusVec;
      default:     busRdData = '0;
    endcase
  end

  assign clkEn  = clkVec[NUM_BLOCKS-1:0];
  assign blkRst = rstReg[NUM_BLOCKS-1:0];

endmodule

// File: rtl/periph_clkrst.sv
module periph_clkrst
  import pcg_pkg::*;
#(
  parameter int unsigned  NUM_BLOCKS      = 12,
  parameter logic [15:0]  CODE_BASE       = 16'h5A00,
  parameter logic [15:0]  HW_OWNED_MASK   = 16'h0009,
  parameter logic [15:0]  UNGATED_MASK    = 16'h00C0,
  parameter logic [15:0]  HAS_RESET_MASK  = 16'h0F7F,
  parameter logic [15:0]  HAS_STATUS_MASK = 16'h0B3F,
  parameter int unsigned  CONSOLE_IDX     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic [2:0]            busAddr,
  input  logic [15:0]           busWrData,
  output logic [15:0]           busRdData,
  input  logic [NUM_BLOCKS-1:0] hwClkReq,
  output logic [NUM_BLOCKS-1:0] clkEn,
  output logic [NUM_BLOCKS-1:0] blkRst
);

  ctrlStrobe_t strobe;

  pcg_ctrl #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .CODE_BASE    (CODE_BASE),
    .HW_OWNED_MASK(HW_OWNED_MASK),
    .UNGATED_MASK (UNGATED_MASK),
    .CONSOLE_IDX  (CONSOLE_IDX)
  ) u_ctrl (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strobe   (strobe)
  );

  pcg_dp #(
    .NUM_BLOCKS     (NUM_BLOCKS),
    .HW_OWNED_MASK  (HW_OWNED_MASK),
    .UNGATED_MASK   (UNGATED_MASK),
    .HAS_RESET_MASK (HAS_RESET_MASK),
    .HAS_STATUS_MASK(HAS_STATUS_MASK),
    .CONSOLE_IDX    (CONSOLE_IDX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .hwClkReq (hwClkReq),
    .busRdData(busRdData),
    .clkEn    (clkEn),
    .blkRst   (blkRst)
  );

endmodule

// File: rtl/periph_clkrst_chk.sv
module periph_clkrst_chk
  import pcg_pkg::*;
#(
  parameter int unsigned  NUM_BLOCKS      = 12,
  parameter logic [15:0]  CODE_BASE       = 16'h5A00,
  parameter logic [15:0]  HW_OWNED_MASK   = 16'h0009,
  parameter logic [15:0]  UNGATED_MASK    = 16'h00C0,
  parameter logic [15:0]  HAS_STATUS_MASK = 16'h0B3F,
  parameter int unsigned  CONSOLE_IDX     = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic [2:0]            busAddr,
  input logic [15:0]           busWrData,
  input logic [15:0]           busRdData,
  input logic [NUM_BLOCKS-1:0] hwClkReq,
  input logic [NUM_BLOCKS-1:0] clkEn,
  input logic [NUM_BLOCKS-1:0] blkRst,
  input ctrlStrobe_t           strobe
);

  localparam logic [NUM_BLOCKS-1:0] SW_MASK =
    ~(HW_OWNED_MASK[NUM_BLOCKS-1:0] | UNGATED_MASK[NUM_BLOCKS-1:0]);

  logic cmdWr;
  assign cmdWr = busWrEn && ((busAddr == ADDR_EN_SET) || (busAddr == ADDR_EN_CLR));

  // R1: a command word never selects more than one block
  a_r1_onehot_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.enSet, strobe.enClr}));

  // R2: the no-gate code leaves every software-gated enable unchanged
  a_r2_ffff_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWrData == 16'hFFFF) |=> $stable(clkEn & SW_MASK));

  // R7: released bits are 0 after the release write
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_RST_OFF) |=> ((blkRst & $past(busWrData[NUM_BLOCKS-1:0])) == '0));

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    localparam logic [15:0] MY_CODE = 16'(CODE_BASE + i);
    if (!HW_OWNED_MASK[i] && !UNGATED_MASK[i] && i != CONSOLE_IDX) begin : g_sw
      a_r1_set_on: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && busAddr == ADDR_EN_SET && busWrData == MY_CODE) |=> clkEn[i]);
      a_r1_clr_off: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && busAddr == ADDR_EN_CLR && busWrData == MY_CODE) |=> !clkEn[i]);
    end
    if (HW_OWNED_MASK[i] && !UNGATED_MASK[i]) begin : g_hw
      a_r3_hw_only: assert property (@(posedge clk) disable iff (!rstN)
        $stable(hwClkReq[i]) |-> $stable(clkEn[i]));
    end
    if (HAS_STATUS_MASK[i]) begin : g_stat
      a_r9_status_bit: assert property (@(posedge clk) disable iff (!rstN)
        (busAddr == ADDR_STATUS) |-> (busRdData[i] == clkEn[i]));
    end
    if (i == CONSOLE_IDX) begin : g_con
      a_r8_console_clk: assert property (@(posedge clk) disable iff (!rstN)
        clkEn[i] |=> clkEn[i]);
      a_r8_console_rst: assert property (@(posedge clk) disable iff (!rstN)
        !blkRst[i] |=> !blkRst[i]);
    end
  end

endmodule

bind periph_clkrst periph_clkrst_chk #(
  .NUM_BLOCKS     (NUM_BLOCKS),
  .CODE_BASE      (CODE_BASE),
  .HW_OWNED_MASK  (HW_OWNED_MASK),
  .UNGATED_MASK   (UNGATED_MASK),
  .HAS_STATUS_MASK(HAS_STATUS_MASK),
  .CONSOLE_IDX    (CONSOLE_IDX)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .hwClkReq (hwClkReq),
  .clkEn    (clkEn),
  .blkRst   (blkRst),
  .strobe   (strobe)
);

// File: tb/sim_periph_clkrst.sv
`timescale 1ns/1ps
module sim_periph_clkrst;

  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0;
  logic [2:0]    busAddr = 3'd0;
  logic [15:0]   busWrData = 16'h0;
  logic [15:0]   busRdData;
  logic [N-1:0]  hwClkReq = '0;
  logic [N-1:0]  clkEn;
  logic [N-1:0]  blkRst;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  periph_clkrst u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .hwClkReq(hwClkReq),
    .clkEn(clkEn), .blkRst(blkRst)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 3'd7; busWrData = 16'h0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R5 blkRst", 16'(blkRst), 16'h0F7F);
    chk("R5 clkEn", 16'(clkEn), 16'h00C0);
    rd(3'd5, v); chk("R5 status", v, 16'h04C0);
    rd(3'd2, v); chk("R5 rst reg", v, 16'h0F7F);
  endtask

  task automatic t_set_clr();
    logic [15:0] v;
    wr(3'd0, 16'h5A09); chk("R1 set9", 16'(clkEn), 16'h02C0);
    rd(3'd5, v);        chk("R9 status set9", v, 16'h06C0);
    wr(3'd0, 16'h5A01);
    wr(3'd0, 16'h5A0B); chk("R1 set1 set11", 16'(clkEn), 16'h0AC2);
    wr(3'd1, 16'h5A09); chk("R1 clr9", 16'(clkEn), 16'h08C2);
  endtask

  task automatic t_bad_codes();
    wr(3'd0, 16'hFFFF); chk("R2 set ffff", 16'(clkEn), 16'h08C2);
    wr(3'd1, 16'hFFFF); chk("R2 clr ffff", 16'(clkEn), 16'h08C2);
    wr(3'd0, 16'h5A0C); chk("R2 code beyond", 16'(clkEn), 16'h08C2);
    wr(3'd1, 16'h1234); chk("R2 unknown code", 16'(clkEn), 16'h08C2);
    wr(3'd1, 16'h5A01);
    wr(3'd1, 16'h5A0B); chk("R1 clr1 clr11", 16'(clkEn), 16'h00C0);
  endtask

  task automatic t_ungated();
    wr(3'd1, 16'h5A06);
    wr(3'd1, 16'h5A07); chk("R4 ungated after clr", 16'(clkEn), 16'h00C0);
  endtask

  task automatic t_status();
    logic [15:0] v;
    wr(3'd0, 16'h5A0A); chk("R1 set10", 16'(clkEn), 16'h04C0);
    wr(3'd1, 16'h5A0A); chk("R1 clr10", 16'(clkEn), 16'h00C0);
    rd(3'd5, v);        chk("R9 status no-bit block", v, 16'h04C0);
  endtask

  task automatic t_hw();
    @(negedge clk); hwClkReq = 12'h009;
    #1 chk("R3 hw follow on", 16'(clkEn), 16'h00C9);
    // command and request change land together
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 3'd1; busWrData = 16'h5A00; hwClkReq = 12'h001;
    #1 chk("R3 hw same cycle", 16'(clkEn), 16'h00C1);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 3'd7;
    #1 chk("R3 sw clr ignored", 16'(clkEn), 16'h00C1);
    @(negedge clk); hwClkReq = '0;
    wr(3'd0, 16'h5A03); chk("R3 sw set ignored", 16'(clkEn), 16'h00C0);
  endtask

  task automatic t_rst_reg();
    logic [15:0] v;
    wr(3'd2, 16'hFFFF); rd(3'd2, v); chk("R6 load ones", v, 16'h0F7F);
    chk("R6 unsupported blkRst", 16'(blkRst), 16'h0F7F);
    wr(3'd2, 16'h0A15); rd(3'd2, v); chk("R6 load pattern", v, 16'h0A15);
    chk("R6 blkRst pattern", 16'(blkRst), 16'h0A15);
  endtask

  task automatic t_rst_atomic();
    logic [15:0] v;
    wr(3'd3, 16'h0060); rd(3'd2, v); chk("R7 assert ones", v, 16'h0A75);
    wr(3'd3, 16'h0080); rd(3'd2, v); chk("R7 assert unsupported", v, 16'h0A75);
    wr(3'd4, 16'h0A01); rd(3'd2, v); chk("R7 release ones", v, 16'h0074);
  endtask

  task automatic t_console();
    logic [15:0] v;
    wr(3'd0, 16'h5A04); chk("R8 console on", 16'(clkEn), 16'h00D0);
    wr(3'd1, 16'h5A04); chk("R8 console clr ignored", 16'(clkEn), 16'h00D0);
    rd(3'd5, v);        chk("R9 status console", v, 16'h04D0);
    wr(3'd4, 16'h0010); rd(3'd2, v); chk("R8 console released", v, 16'h0064);
    wr(3'd3, 16'h0010); rd(3'd2, v); chk("R8 console no reassert", v, 16'h0064);
    wr(3'd2, 16'h0FFF); rd(3'd2, v); chk("R8 load skips console", v, 16'h0F6F);
    chk("R8 blkRst console", 16'(blkRst), 16'h0F6F);
  endtask

  task automatic t_addr();
    logic [15:0] v;
    rd(3'd0, v); chk("R10 read addr0", v, 16'h0);
    rd(3'd1, v); chk("R10 read addr1", v, 16'h0);
    rd(3'd6, v); chk("R10 read addr6", v, 16'h0);
    rd(3'd7, v); chk("R10 read addr7", v, 16'h0);
    wr(3'd6, 16'h5A09);
    wr(3'd7, 16'h0000);
    chk("R10 clkEn unchanged", 16'(clkEn), 16'h00D0);
    chk("R10 blkRst unchanged", 16'(blkRst), 16'h0F6F);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_set_clr();
    t_bad_codes();
    t_ungated();
    t_status();
    t_hw();
    t_rst_reg();
    t_rst_atomic();
    t_console();
    t_addr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule